// File: doc/BRIEF.md
# Dot-Matrix Scroll Offset Controller

This block produces the scroll displacement used by an LED matrix scan engine. Software programs a direction, a per-step period, a step count and a page mode through a small write-only register port. It then launches a scroll by setting a start bit. A millisecond tick paces the motion. On each timed step the block moves a horizontal or vertical offset by one dot.

The scan engine presents the display coordinate it is about to light. The block returns the source coordinate and the frame (0 or 1) that should be read for that dot. In single-page mode the content wraps around within the shown frame. In two-page mode the other frame slides in behind it. A sticky end-of-scroll flag is raised when the programmed number of steps has been taken. Software clears it with a write. The position that was reached is held until scrolling is disabled.

The matrix can be the full size (17 columns by 7 rows by default) or a reduced size (15 by 5), chosen by an input pin.

Top module: `scroll_offset_ctrl`

## Requirements
- R1: After reset the offset is 0, the busy output is 0 and the end flag is 0.
- R2: Register writes are decoded by address. At address 0: bits 1:0 are the direction (0 right, 1 left, 2 up, 3 down), bit 2 selects two-page mode, bits 6:3 are the speed code and bit 7 is the enable. At address 1: bits 5:0 are the step count and bit 7 is the start bit. At address 2: writing bit 0 as 1 clears the end flag. Writes to any other address change nothing.
- R3: A scroll launches only on a write to address 1 that changes the stored start bit from 0 to 1 while enable is 1. Busy is 1 on the following cycle. A start write while disabled, or while the stored start bit is already 1, launches nothing.
- R4: While busy, the offset advances by exactly one dot after every (code+1)×MS_PER_UNIT millisecond ticks, counted from the launch.
- R5: A scroll takes the programmed number of steps and then stops. A count of 0 means one page span along the moving axis. A count above twice the span is limited to twice the span.
- R6: The offset wraps to 0 when it reaches twice the page span of the moving axis.
- R7: For left or up, a display coordinate c reads source position c+offset. For right or down it reads c−offset. Both are taken modulo twice the span, and a position at or beyond the span maps back by subtracting the span. The coordinate on the other axis passes through unchanged.
- R8: In single-page mode the output frame always equals the displayed frame. In two-page mode a position that falls in the upper span reads the other frame.
- R9: The end flag is set on the cycle after the final step and stays set until a clear write. A clear in the same cycle as a final step leaves the flag set.
- R10: A write of enable as 0 forces the offset to 0 and busy to 0 on the next cycle. Otherwise, once a scroll ends, the reached offset is held.
- R11: With the compact input high the spans are 15 columns and 5 rows; otherwise 17 columns and 7 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| compact_mode | input | 1 | Selects the reduced matrix size |
| display_frame | input | 1 | Frame currently shown |
| scan_col | input | COL_W | Display column being scanned |
| scan_row | input | ROW_W | Display row being scanned |
| scroll_offset | output | OFF_W | Current scroll displacement in dots |
| scroll_busy | output | 1 | High while a scroll is in progress |
| scroll_irq | output | 1 | Sticky end-of-scroll flag |
| src_col | output | COL_W | Column to read from frame storage |
| src_row | output | ROW_W | Row to read from frame storage |
| src_frame | output | 1 | Frame to read from frame storage |

## Verification
The assertions assume several things about the inputs. The tick is a single-cycle pulse. The scan coordinates stay inside the visible page of the selected size. Software does not switch the moving axis or the matrix size while a scroll runs. The stimulus changes direction and size only while the block is idle or disabled, and it derives the scan coordinates modulo the current page size. The reference model follows the register semantics written above, and every cycle its offset, busy, flag and mapped coordinate are compared with the design.

// File: rtl/scroll_pkg.sv
package scroll_pkg;

   typedef enum logic [1:0] {
      DIR_RIGHT = 2'd0,
      DIR_LEFT  = 2'd1,
      DIR_UP    = 2'd2,
      DIR_DOWN  = 2'd3
   } scroll_dir_e;

   // Field order matches the bit layout of configuration register 0
   typedef struct packed {
      logic        en;
      logic [3:0]  speed;
      logic        wrap_pages;
      scroll_dir_e dir;
   } scroll_cfg_t;

   localparam int unsigned REG_CFG = 0;
   localparam int unsigned REG_RUN = 1;
   localparam int unsigned REG_ACK = 2;
   localparam int unsigned SPD_W   = 4;

   function automatic logic is_horizontal(scroll_dir_e d);
      return !d[1];
   endfunction

   function automatic logic is_forward(scroll_dir_e d);
      return (d == DIR_LEFT) || (d == DIR_UP);
   endfunction

endpackage

// File: rtl/scroll_regs.sv
module scroll_regs
   import scroll_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   output scroll_cfg_t       cfg,
   output logic              start,
   output logic              stop,
   output logic              ack,
   output logic [CNT_W-1:0]  launch_count
);

   generate
      if (CNT_W < 1 || CNT_W > 7) begin : g_bad_cnt
         $error("scroll_regs: CNT_W must lie in 1..7");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("scroll_regs: ADDR_W must be at least 2");
      end
   endgenerate

   logic hit_cfg, hit_run, hit_ack;
   logic go_q;

   assign hit_cfg = wr_en && (wr_addr == ADDR_W'(REG_CFG));
   assign hit_run = wr_en && (wr_addr == ADDR_W'(REG_RUN));
   assign hit_ack = wr_en && (wr_addr == ADDR_W'(REG_ACK));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         go_q <= 1'b0;
      end else begin
         if (hit_cfg) cfg <= scroll_cfg_t'(wr_data);
         if (hit_run) go_q <= wr_data[7];
      end
   end

   assign start        = hit_run && wr_data[7] && !go_q && cfg.en;
   assign stop         = hit_cfg && !wr_data[7];
   assign ack          = hit_ack && wr_data[0];
   assign launch_count = wr_data[CNT_W-1:0];

endmodule

// File: rtl/scroll_stepper.sv
module scroll_stepper
   import scroll_pkg::*;
#(
   parameter int OFF_W       = 6,
   parameter int CNT_W       = 6,
   parameter int MS_PER_UNIT = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [SPD_W-1:0] speed,
   input  logic [OFF_W-1:0] span,
   input  logic             start,
   input  logic             stop,
   input  logic             ack,
   input  logic [CNT_W-1:0] launch_count,
   output logic [OFF_W-1:0] offset,
   output logic             busy,
   output logic             done_flag
);

   localparam int TMR_W = $clog2((2**SPD_W) * MS_PER_UNIT + 1);
   localparam int SW    = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;

   logic [TMR_W-1:0] tcnt, limit_m1;
   logic [SW-1:0]    span_w, span2_w, cnt_w, total, remaining, inc;
   logic [OFF_W-1:0] off_next;
   logic             step, finish;

   assign span_w   = SW'(span);
   assign span2_w  = span_w << 1;
   assign cnt_w    = SW'(launch_count);
   assign total    = (cnt_w == '0) ? span_w :
                     ((cnt_w > span2_w) ? span2_w : cnt_w);
   assign limit_m1 = TMR_W'((int'(speed) + 1) * MS_PER_UNIT - 1);
   assign inc      = SW'(offset) + SW'(1);
   assign off_next = (inc >= span2_w) ? '0 : OFF_W'(inc);
   assign step     = busy && ms_tick && (tcnt == limit_m1);
   assign finish   = step && (remaining == SW'(1)) && !stop && !start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset    <= '0;
         busy      <= 1'b0;
         tcnt      <= '0;
         remaining <= '0;
         done_flag <= 1'b0;
      end else begin
         if (stop) begin
            offset <= '0;
            busy   <= 1'b0;
            tcnt   <= '0;
         end else if (start) begin
            busy      <= 1'b1;
            remaining <= total;
            tcnt      <= '0;
         end else if (busy && ms_tick) begin
            if (step) begin
               tcnt      <= '0;
               offset    <= off_next;
               remaining <= remaining - SW'(1);
               if (remaining == SW'(1)) busy <= 1'b0;
            end else begin
               tcnt <= tcnt + TMR_W'(1);
            end
         end
         if (finish)   done_flag <= 1'b1;
         else if (ack) done_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/scroll_map.sv
module scroll_map
   import scroll_pkg::*;
#(
   parameter int COL_W = 5,
   parameter int ROW_W = 3,
   parameter int OFF_W = 6
) (
   input  scroll_dir_e      dir,
   input  logic             wrap_pages,
   input  logic             display_frame,
   input  logic [OFF_W-1:0] offset,
   input  logic [OFF_W-1:0] span,
   input  logic [COL_W-1:0] scan_col,
   input  logic [ROW_W-1:0] scan_row,
   output logic [COL_W-1:0] src_col,
   output logic [ROW_W-1:0] src_row,
   output logic             src_frame
);

   localparam int PW = OFF_W + 2;

   logic [PW-1:0] span_p, span2_p, off_m, coord, pos, pos_w, idx;
   logic          horiz, upper;

   assign horiz   = is_horizontal(dir);
   assign span_p  = PW'(span);
   assign span2_p = span_p << 1;
   assign off_m   = PW'(offset) % span2_p;
   assign coord   = horiz ? PW'(scan_col) : PW'(scan_row);
   assign pos     = is_forward(dir) ? (coord + off_m) : (coord + span2_p - off_m);
   assign pos_w   = (pos >= span2_p) ? (pos - span2_p) : pos;
   assign upper   = (pos_w >= span_p);
   assign idx     = upper ? (pos_w - span_p) : pos_w;

   assign src_col   = horiz ? COL_W'(idx) : scan_col;
   assign src_row   = horiz ? scan_row : ROW_W'(idx);
   assign src_frame = display_frame ^ (wrap_pages & upper);

endmodule

// File: rtl/scroll_offset_ctrl.sv
module scroll_offset_ctrl
   import scroll_pkg::*;
#(
   parameter int FULL_COLS   = 17,
   parameter int FULL_ROWS   = 7,
   parameter int SMALL_COLS  = 15,
   parameter int SMALL_ROWS  = 5,
   parameter int MS_PER_UNIT = 50,
   parameter int ADDR_W      = 4,
   parameter int CNT_W       = 6,
   localparam int COL_W      = $clog2(FULL_COLS),
   localparam int ROW_W      = $clog2(FULL_ROWS),
   localparam int OFF_W      = $clog2(2 * FULL_COLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              compact_mode,
   input  logic              display_frame,
   input  logic [COL_W-1:0]  scan_col,
   input  logic [ROW_W-1:0]  scan_row,
   output logic [OFF_W-1:0]  scroll_offset,
   output logic              scroll_busy,
   output logic              scroll_irq,
   output logic [COL_W-1:0]  src_col,
   output logic [ROW_W-1:0]  src_row,
   output logic              src_frame
);

   generate
      if (FULL_ROWS > FULL_COLS || SMALL_COLS > FULL_COLS ||
          SMALL_ROWS > FULL_ROWS || SMALL_ROWS < 2 || MS_PER_UNIT < 1) begin : g_bad_geom
         $error("scroll_offset_ctrl: inconsistent matrix geometry or tick scale");
      end
   endgenerate

   scroll_cfg_t           cfg;
   logic                  start, stop, ack;
   logic [CNT_W-1:0]      launch_count;
   logic [OFF_W-1:0]      span;

   always_comb begin
      if (is_horizontal(cfg.dir))
         span = compact_mode ? OFF_W'(SMALL_COLS) : OFF_W'(FULL_COLS);
      else
         span = compact_mode ? OFF_W'(SMALL_ROWS) : OFF_W'(FULL_ROWS);
   end

   scroll_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cfg(cfg), .start(start), .stop(stop), .ack(ack), .launch_count(launch_count)
   );

   scroll_stepper #(.OFF_W(OFF_W), .CNT_W(CNT_W), .MS_PER_UNIT(MS_PER_UNIT)) u_step (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .speed(cfg.speed), .span(span),
      .start(start), .stop(stop), .ack(ack), .launch_count(launch_count),
      .offset(scroll_offset), .busy(scroll_busy), .done_flag(scroll_irq)
   );

   scroll_map #(.COL_W(COL_W), .ROW_W(ROW_W), .OFF_W(OFF_W)) u_map (
      .dir(cfg.dir), .wrap_pages(cfg.wrap_pages), .display_frame(display_frame),
      .offset(scroll_offset), .span(span), .scan_col(scan_col), .scan_row(scan_row),
      .src_col(src_col), .src_row(src_row), .src_frame(src_frame)
   );

endmodule

// File: rtl/scroll_offset_chk.sv
module scroll_offset_chk #(
   parameter int OFF_W     = 6,
   parameter int FULL_COLS = 17
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             wrap_pages,
   input logic             display_frame,
   input logic             src_frame,
   input logic             start,
   input logic             ack,
   input logic [OFF_W-1:0] offset,
   input logic             busy,
   input logic             flag
);

   AST_OFFSET_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      offset < OFF_W'(2 * FULL_COLS)); // R6

   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (offset == '0) && !busy); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) && !$past(start) && en |-> $stable(offset)); // R10

   AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) && en |-> (offset == $past(offset)) ||
                            (offset == $past(offset) + OFF_W'(1)) || (offset == '0)); // R4

   AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R3

   AST_FLAG_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && en |-> flag); // R9

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(flag) && !$past(ack) |-> flag); // R9

   AST_SINGLE_PAGE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_pages |-> src_frame == display_frame); // R8

endmodule

bind scroll_offset_ctrl scroll_offset_chk #(.OFF_W(OFF_W), .FULL_COLS(FULL_COLS)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(cfg.en), .wrap_pages(cfg.wrap_pages),
   .display_frame(display_frame), .src_frame(src_frame), .start(start), .ack(ack),
   .offset(scroll_offset), .busy(scroll_busy), .flag(scroll_irq)
);

// File: tb/tb_scroll_offset_ctrl.sv
module tb_scroll_offset_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int MSU        = 50;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       compact_mode = 1'b0;
   logic       display_frame = 1'b0;
   logic [4:0] scan_col = '0;
   logic [2:0] scan_row = '0;
   logic [5:0] scroll_offset;
   logic       scroll_busy, scroll_irq, src_frame;
   logic [4:0] src_col;
   logic [2:0] src_row;

   scroll_offset_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .compact_mode(compact_mode), .display_frame(display_frame),
      .scan_col(scan_col), .scan_row(scan_row), .scroll_offset(scroll_offset),
      .scroll_busy(scroll_busy), .scroll_irq(scroll_irq), .src_col(src_col),
      .src_row(src_row), .src_frame(src_frame)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   int  cyc = 0;
   int  tick_div = 1;

   // reference model state
   int m_en, m_spd, m_wrap, m_dir, m_go, m_off, m_busy, m_irq, m_tcnt, m_rem;

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int span_of(int dir, bit compact);
      if (dir < 2) return compact ? 15 : 17;
      return compact ? 5 : 7;
   endfunction

   function automatic int cfgb(int en, int spd, int wrap, int dir);
      return (en << 7) | (spd << 3) | (wrap << 2) | dir;
   endfunction

   // stimulus on scan and tick inputs
   always @(negedge clk) begin
      cyc++;
      ms_tick  <= (cyc % tick_div) == 0;
      scan_col <= 5'(cyc % (compact_mode ? 15 : 17));
      scan_row <= 3'((cyc / 3) % (compact_mode ? 5 : 7));
   end

   // behavioural reference model
   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_spd = 0; m_wrap = 0; m_dir = 0; m_go = 0;
         m_off = 0; m_busy = 0; m_irq = 0; m_tcnt = 0; m_rem = 0;
      end else begin
         bit dis, st, clr, fin;
         int sp, cnt;
         dis = wr_en && wr_addr == 0 && !wr_data[7];
         st  = wr_en && wr_addr == 1 && wr_data[7] && m_go == 0 && m_en == 1;
         clr = wr_en && wr_addr == 2 && wr_data[0];
         sp  = span_of(m_dir, compact_mode);
         fin = 0;
         if (dis) begin
            m_off = 0; m_busy = 0; m_tcnt = 0;
         end else if (st) begin
            cnt = int'(wr_data[5:0]);
            m_busy = 1; m_tcnt = 0;
            m_rem = (cnt == 0) ? sp : ((cnt > 2 * sp) ? 2 * sp : cnt);
         end else if (m_busy == 1 && ms_tick) begin
            if (m_tcnt == (m_spd + 1) * MSU - 1) begin
               m_tcnt = 0;
               m_off = (m_off + 1 >= 2 * sp) ? 0 : m_off + 1;
               if (m_rem == 1) begin m_busy = 0; fin = 1; end
               m_rem--;
            end else m_tcnt++;
         end
         if (fin) m_irq = 1;
         else if (clr) m_irq = 0;
         if (wr_en && wr_addr == 0) begin
            m_en = wr_data[7]; m_spd = int'(wr_data[6:3]);
            m_wrap = wr_data[2]; m_dir = int'(wr_data[1:0]);
         end
         if (wr_en && wr_addr == 1) m_go = wr_data[7];
      end
   end

   // every-cycle comparison
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         int sp, o, c, p, half, idx, efr, ecol, erow;
         sp = span_of(m_dir, compact_mode);
         o = m_off % (2 * sp);
         c = (m_dir < 2) ? int'(scan_col) : int'(scan_row);
         p = (m_dir == 1 || m_dir == 2) ? c + o : c + 2 * sp - o;
         p = p % (2 * sp);
         half = (p >= sp) ? 1 : 0;
         idx = half ? p - sp : p;
         efr = (m_wrap == 1) ? (int'(display_frame) ^ half) : int'(display_frame);
         ecol = (m_dir < 2) ? idx : int'(scan_col);
         erow = (m_dir < 2) ? int'(scan_row) : idx;
         check(int'(scroll_offset) == m_off, "R4", "offset", int'(scroll_offset), m_off);
         check(int'(scroll_busy) == m_busy, "R5", "busy", int'(scroll_busy), m_busy);
         check(int'(scroll_irq) == m_irq, "R9", "end flag", int'(scroll_irq), m_irq);
         check(int'(src_col) == ecol, "R7", "src_col", int'(src_col), ecol);
         check(int'(src_row) == erow, "R7", "src_row", int'(src_row), erow);
         check(int'(src_frame) == efr, "R8", "src_frame", int'(src_frame), efr);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      wr_en <= 1'b1; wr_addr <= 4'(a); wr_data <= 8'(d);
      @(negedge clk);
      wr_en <= 1'b0;
   endtask

   task automatic wait_idle(output int busy_cycles);
      busy_cycles = 0;
      while (scroll_busy && busy_cycles < 20000) begin
         @(negedge clk);
         busy_cycles++;
      end
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int bc;
      repeat (3) @(negedge clk);
      check(scroll_offset == 0, "R1", "reset offset", int'(scroll_offset), 0);
      check(scroll_busy == 0, "R1", "reset busy", int'(scroll_busy), 0);
      check(scroll_irq == 0, "R1", "reset flag", int'(scroll_irq), 0);
      rst_n = 1'b1;

      // right, single page, three steps
      wr(0, cfgb(1, 0, 0, 0));
      wr(1, 8'h80 | 3);
      wait_idle(bc);
      check(scroll_offset == 3, "R5", "count 3 offset", int'(scroll_offset), 3);
      check(scroll_irq == 1, "R9", "flag after end", int'(scroll_irq), 1);
      repeat (120) @(negedge clk);
      check(scroll_offset == 3, "R10", "held offset", int'(scroll_offset), 3);
      wr(2, 1);
      check(scroll_irq == 0, "R9", "flag cleared", int'(scroll_irq), 0);

      // start bit already high: no launch
      wr(1, 8'h80 | 5);
      @(negedge clk);
      check(scroll_busy == 0, "R3", "no rise no start", int'(scroll_busy), 0);

      // left, two pages, count 0 = one page
      wr(0, cfgb(1, 0, 1, 1));
      wr(1, 0);
      wr(1, 8'h80);
      wait_idle(bc);
      check(scroll_offset == 20, "R5", "one page from 3", int'(scroll_offset), 20);

      // disable clears, start while disabled ignored
      wr(0, cfgb(0, 0, 1, 1));
      check(scroll_offset == 0, "R10", "disable offset", int'(scroll_offset), 0);
      check(scroll_busy == 0, "R10", "disable busy", int'(scroll_busy), 0);
      wr(1, 0);
      wr(1, 8'h84);
      @(negedge clk);
      check(scroll_busy == 0, "R3", "start while disabled", int'(scroll_busy), 0);

      // up, count clamped to 14, wraps to 0
      wr(2, 1);
      wr(0, cfgb(1, 0, 0, 2));
      wr(1, 0);
      wr(1, 8'h80 | 50);
      wait_idle(bc);
      check(bc == 14 * MSU, "R5", "clamped busy cycles", bc, 14 * MSU);
      check(scroll_offset == 0, "R6", "wrap at twice span", int'(scroll_offset), 0);
      check(scroll_irq == 1, "R9", "flag after clamp", int'(scroll_irq), 1);

      // step period with speed code 1
      wr(2, 1);
      wr(0, cfgb(1, 1, 0, 0));
      wr(1, 0);
      wr(1, 8'h82);
      repeat (99) @(negedge clk);
      check(scroll_offset == 0, "R4", "before period", int'(scroll_offset), 0);
      @(negedge clk);
      check(scroll_offset == 1, "R4", "at period", int'(scroll_offset), 1);
      wait_idle(bc);

      // unmapped addresses ignored; configuration kept
      wr(3, 8'hFF);
      wr(15, 8'h00);
      check(scroll_offset == 2, "R2", "offset after stray", int'(scroll_offset), 2);
      check(scroll_irq == 1, "R2", "flag after stray", int'(scroll_irq), 1);
      wr(1, 0);
      wr(1, 8'h81);
      check(scroll_busy == 1, "R2", "still enabled", int'(scroll_busy), 1);
      wait_idle(bc);

      // compact matrix, down, two pages, sparse ticks
      wr(0, 0);
      compact_mode = 1'b1;
      display_frame = 1'b1;
      tick_div = 3;
      wr(0, cfgb(1, 2, 1, 3));
      wr(1, 0);
      wr(1, 8'h80);
      wait_idle(bc);
      check(scroll_offset == 5, "R11", "compact row page", int'(scroll_offset), 5);
      #1;
      check(src_frame == 0, "R8", "other frame", int'(src_frame), 0);
      check(src_row == scan_row, "R7", "row shifted a page", int'(src_row), int'(scan_row));

      repeat (5) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule